// File: doc/BRIEF.md
# Two-Range Serial Clock Divider

This block derives the master clock of a point-to-point encoder link from the system clock. A divider code selects the output period. The code space is split into two ranges. Low codes give a fine range whose period grows by 2 system clocks per code step. High codes give a coarse range whose period grows by 20 system clocks per step. The output clock rests high. Each period starts with a low phase, and the low and high phases are always the same length. A code change or a disable takes effect only at a period boundary, so the output never carries a shortened pulse.

Beside the clock, the block contains a processing-delay counter for the frame controller. A start pulse loads an 8-bit busy count. The counter then counts output clock periods and raises a single done pulse once that many periods have elapsed. The delay therefore equals the busy count multiplied by the output period.

All pins are plain control and status signals. No data moves across the block's edge, so it has no valid/ready handshake and no back-pressure.

Top module: `link_clk_gen`

## Requirements
- R1: For `div_code` 0 to 15, the output period is 2×(code+1) system clocks, with `sclk_out` low for code+1 cycles and then high for code+1 cycles.
- R2: For `div_code` 16 to 31, the output period is 20×(code−15) system clocks, with equal low and high phases of 10×(code−15) cycles.
- R3: `code_invalid` is 1 in the same cycle that `div_code` is 32 or above, and 0 otherwise. If the code is invalid at a period boundary, no new period starts: `sclk_out` stays high and `period_tick` stays 0 until a valid code is applied.
- R4: While `rst_n` is low, and while `en` is low with no period running, `sclk_out` is 1 and `period_tick` and `busy_done` are 0. If `en` is dropped during a period, that period still completes at full length, and the clock then rests high.
- R5: A new `div_code` is sampled only at a period boundary. The period that is running when the code changes keeps its original low and high lengths.
- R6: `period_tick` is 1 for exactly one system clock, in the first cycle in which `sclk_out` is 0 after having been 1. That is the first cycle of every period.
- R7: A cycle with `busy_start` high latches `busy_count` = N. Period ticks that appear after the start cycle are counted, and a tick that is present in the start cycle itself is not. `busy_done` pulses for one cycle, in the cycle that follows the Nth counted tick, and it pulses only once per start.
- R8: If `busy_count` is 0 when `busy_start` is high, `busy_done` pulses in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Allows new output periods to start |
| div_code | input | 6 | Divider code. Values 0–15 select the fine range, 16–31 the coarse range, and 32 and above are invalid |
| busy_count | input | 8 | Processing delay in output periods, latched when a start is seen |
| busy_start | input | 1 | Starts the processing-delay count |
| sclk_out | output | 1 | Divided clock; rests high |
| period_tick | output | 1 | One-cycle pulse on each falling edge of `sclk_out` |
| busy_done | output | 1 | One-cycle pulse when the processing delay has elapsed |
| code_invalid | output | 1 | High while `div_code` is out of range |

## Verification
The hardest cases to reach from the ports are those where two events fall on a period boundary at the same time. The first is a code change that lands in the middle of a long coarse period. The second is a delay start that coincides with a tick, where that tick must not be counted. The stimulus reaches both by synchronising to an observed tick. It then changes the code, or pulses start, on that same sampling point or a random small number of cycles later. This puts the event at the exact boundary as well as just after it, and the bench then measures the following phases cycle by cycle.

// File: rtl/link_clk_pkg.sv
package link_clk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/lcg_code_decode.sv
// Maps a divider code to a half-period length and flags codes that are out of range.
module lcg_code_decode #(
  parameter int CODE_W      = 6,
  parameter int FINE_CODES  = 16,
  parameter int NUM_CODES   = 32,
  parameter int FINE_HALF   = 1,
  parameter int COARSE_HALF = 10,
  parameter int HALF_W      = 8
) (
  input  logic [CODE_W-1:0] code,
  output logic [HALF_W-1:0] half,
  output logic              valid
);
  always_comb begin
    valid = (code < CODE_W'(NUM_CODES));
    if (code < CODE_W'(FINE_CODES)) begin
      half = HALF_W'(FINE_HALF) * (HALF_W'(code) + HALF_W'(1));
    end else begin
      half = HALF_W'(COARSE_HALF) * (HALF_W'(code) - HALF_W'(FINE_CODES - 1));
    end
  end
endmodule

// File: rtl/lcg_phase_gen.sv
// Produces the divided clock. A new code is loaded only when a period begins.
module lcg_phase_gen
  import link_clk_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              code_ok,
  input  logic [HALF_W-1:0] new_half,
  output logic              sclk,
  output logic              tick
);
  phase_e            st;
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_q;
  logic              start_period;

  always_comb begin
    start_period = en && code_ok &&
                   ((st == PH_IDLE) || ((st == PH_HIGH) && (cnt == '0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PH_IDLE;
      cnt    <= '0;
      half_q <= '0;
      sclk   <= 1'b1;
      tick   <= 1'b0;
    end else begin
      tick <= start_period;
      if (start_period) begin
        half_q <= new_half;
        cnt    <= new_half - HALF_W'(1);
        sclk   <= 1'b0;
        st     <= PH_LOW;
      end else begin
        case (st)
          PH_LOW: begin
            if (cnt == '0) begin
              sclk <= 1'b1;
              cnt  <= half_q - HALF_W'(1);
              st   <= PH_HIGH;
            end else begin
              cnt <= cnt - HALF_W'(1);
            end
          end
          PH_HIGH: begin
            if (cnt == '0) begin
              st <= PH_IDLE;
            end else begin
              cnt <= cnt - HALF_W'(1);
            end
          end
          default: st <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcg_busy_count.sv
// Counts output periods after a start and pulses done once the programmed count is reached.
module lcg_busy_count #(
  parameter int BUSY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUSY_W-1:0] limit,
  input  logic              tick,
  output logic              done
);
  logic              active;
  logic [BUSY_W-1:0] tgt;
  logic [BUSY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tgt    <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        tgt    <= limit;
        cnt    <= '0;
        active <= (limit != '0);
        done   <= (limit == '0);
      end else if (active && tick) begin
        if ((cnt + BUSY_W'(1)) == tgt) begin
          done   <= 1'b1;
          active <= 1'b0;
        end else begin
          cnt <= cnt + BUSY_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/link_clk_gen.sv
module link_clk_gen #(
  parameter int CODE_W      = 6,
  parameter int BUSY_W      = 8,
  parameter int FINE_CODES  = 16,
  parameter int NUM_CODES   = 32,
  parameter int FINE_STEP   = 2,
  parameter int COARSE_STEP = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] div_code,
  input  logic [BUSY_W-1:0] busy_count,
  input  logic              busy_start,
  output logic              sclk_out,
  output logic              period_tick,
  output logic              busy_done,
  output logic              code_invalid
);
  localparam int FINE_HALF   = FINE_STEP / 2;
  localparam int COARSE_HALF = COARSE_STEP / 2;
  localparam int MAX_HALF    = COARSE_HALF * (NUM_CODES - FINE_CODES);
  localparam int HALF_W      = $clog2(MAX_HALF + 1);

  logic [HALF_W-1:0] half_len;
  logic              code_ok;

  lcg_code_decode #(
    .CODE_W(CODE_W), .FINE_CODES(FINE_CODES), .NUM_CODES(NUM_CODES),
    .FINE_HALF(FINE_HALF), .COARSE_HALF(COARSE_HALF), .HALF_W(HALF_W)
  ) u_decode (
    .code (div_code),
    .half (half_len),
    .valid(code_ok)
  );

  lcg_phase_gen #(.HALF_W(HALF_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .code_ok (code_ok),
    .new_half(half_len),
    .sclk    (sclk_out),
    .tick    (period_tick)
  );

  lcg_busy_count #(.BUSY_W(BUSY_W)) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .start(busy_start),
    .limit(busy_count),
    .tick (period_tick),
    .done (busy_done)
  );

  assign code_invalid = !code_ok;
endmodule

// File: rtl/link_clk_gen_chk.sv
module link_clk_gen_chk #(
  parameter int CODE_W = 6,
  parameter int BUSY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [CODE_W-1:0] div_code,
  input logic [BUSY_W-1:0] busy_count,
  input logic              busy_start,
  input logic              sclk_out,
  input logic              period_tick,
  input logic              busy_done,
  input logic              code_invalid
);
  assert_tick_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |-> (!sclk_out && $past(sclk_out)));

  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> !period_tick);

  assert_tick_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |-> ($past(en) && !$past(code_invalid)));

  assert_idle_stays_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_out && !en) |=> sclk_out);

  assert_done_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done |=> (!busy_done || $past(busy_start)));

  assert_zero_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_start && (busy_count == '0)) |=> busy_done);
endmodule

bind link_clk_gen link_clk_gen_chk #(.CODE_W(CODE_W), .BUSY_W(BUSY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .div_code(div_code), .busy_count(busy_count),
  .busy_start(busy_start), .sclk_out(sclk_out), .period_tick(period_tick),
  .busy_done(busy_done), .code_invalid(code_invalid)
);

// File: tb/link_clk_gen_tb.sv
module link_clk_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [5:0] div_code;
  logic [7:0] busy_count;
  logic       busy_start;
  logic       sclk_out, period_tick, busy_done, code_invalid;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  link_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_code(div_code), .busy_count(busy_count),
    .busy_start(busy_start), .sclk_out(sclk_out), .period_tick(period_tick),
    .busy_done(busy_done), .code_invalid(code_invalid)
  );

  function automatic int half_of(int c);
    return (c < 16) ? (c + 1) : (10 * (c - 15));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (period_tick) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  // Called on a sample where period_tick is 1; counts the low and high cycles up to the next tick.
  task automatic measure(output int lo, output int hi);
    lo = 1;
    hi = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (period_tick) break;
      if (sclk_out) hi++;
      else lo++;
    end
    chk(period_tick && !sclk_out && hi > 0, "R6 tick on falling edge", int'(period_tick), 1);
  endtask

  task automatic run_code(input int c);
    bit seen;
    int lo, hi;
    div_code = 6'(c);
    en = 1'b1;
    wait_tick(1000, seen);
    chk(!code_invalid, "R3 legal code not flagged", int'(code_invalid), 0);
    measure(lo, hi);
    if (c < 16) begin
      chk(lo == half_of(c), "R1 low phase", lo, half_of(c));
      chk(hi == half_of(c), "R1 high phase", hi, half_of(c));
    end else begin
      chk(lo == half_of(c), "R2 low phase", lo, half_of(c));
      chk(hi == half_of(c), "R2 high phase", hi, half_of(c));
    end
  endtask

  task automatic busy_run(input int c, input int n, input int offset);
    bit seen, fired;
    int k, errs;
    div_code = 6'(c);
    en = 1'b1;
    wait_tick(1000, seen);
    repeat (offset) @(negedge clk);
    busy_count = 8'(n);
    busy_start = 1'b1;
    k = 0;
    fired = 1'b0;
    errs = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (i == 0) busy_start = 1'b0;
      if (busy_done !== ((k == n) && !fired)) errs++;
      if (busy_done) fired = 1'b1;
      if (period_tick) k++;
      if (fired && k > n) break;
    end
    if (n == 0) chk(fired && errs == 0, "R8 zero count done next cycle", errs, 0);
    else        chk(fired && errs == 0, "R7 done after Nth tick", errs, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    int lo, hi, cnt0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = 1'b0; div_code = '0; busy_count = '0; busy_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclk_out && !period_tick && !busy_done, "R4 reset state", int'(sclk_out), 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sclk_out && !period_tick, "R4 disabled idle high", int'(sclk_out), 1);

    // R1 R2 directed corners then random codes
    run_code(0); run_code(15); run_code(16); run_code(31);
    for (int i = 0; i < 12; i++) run_code(int'($urandom % 32));

    // R5: change the code right at the start of a long period
    div_code = 6'd31;
    wait_tick(1000, seen);
    measure(lo, hi);
    div_code = 6'd0;
    measure(lo, hi);
    chk(lo == 160 && hi == 160, "R5 running period kept", lo, 160);
    measure(lo, hi);
    chk(lo == 1 && hi == 1, "R5 new code next period", lo, 1);

    // R3: invalid code parks the clock high
    div_code = 6'd40;
    @(negedge clk);
    chk(code_invalid == 1'b1, "R3 flag raised", int'(code_invalid), 1);
    wait_tick(600, seen);
    chk(!seen && sclk_out, "R3 no period on invalid code", int'(seen), 0);
    div_code = 6'd63;
    @(negedge clk);
    chk(code_invalid == 1'b1, "R3 flag top code", int'(code_invalid), 1);
    div_code = 6'd2;
    wait_tick(1000, seen);
    chk(!code_invalid, "R3 flag cleared", int'(code_invalid), 0);
    measure(lo, hi);
    chk(lo == 3 && hi == 3, "R3 resume after legal code", lo, 3);

    // R4: drop enable at the start of a period
    div_code = 6'd5;
    wait_tick(1000, seen);
    wait_tick(1000, seen);
    en = 1'b0;
    cnt0 = 1;
    while (!sclk_out && cnt0 < 1000) begin
      @(negedge clk);
      if (!sclk_out) cnt0++;
    end
    chk(cnt0 == 6, "R4 period completes after disable", cnt0, 6);
    wait_tick(200, seen);
    chk(!seen && sclk_out, "R4 rests high when disabled", int'(seen), 0);

    // R7 R8 processing delay
    busy_run(0, 0, 0);
    busy_run(7, 0, 3);
    busy_run(0, 1, 0);
    busy_run(3, 4, 0);
    busy_run(16, 2, 1);
    busy_run(0, 255, 2);
    for (int i = 0; i < 6; i++)
      busy_run(int'($urandom % 4), int'($urandom % 40) + 1, int'($urandom % 5));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule